// File: doc/BRIEF.md
# Real-Time Clock With Alarm and Periodic Timer

This block keeps time as a 40-bit counter that advances once per slow tick enable. The slow tick is expected at 32.768 kHz, so one count is about 30.5 µs and the full range lasts a little over 388 days. A 40-bit alarm value is compared against the counter. A warning flag is raised when the counter enters its final stretch before it wraps. A separate 16-bit down-counter runs from a faster tick enable and raises a flag each time its programmed period runs out.

Software reaches the block through a simple word-wide register port with a single-cycle write strobe and a read strobe. Each of the three event flags holds until software clears it, and a flag drives the shared interrupt line only when its enable bit is set. A new time value is staged and takes effect at the next slow tick. Reading the low time word freezes the high byte, so a two-word read stays coherent across a carry.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the time counter reads 0, the alarm reads all ones (0xFFFFFFFF at address 2), the flag register (address 6) and the enable register (address 7) read 0, and `irq` is low.
- R2: The time counter advances by exactly one on each cycle with `slow_tick` high and holds otherwise. It can be read through the low word at address 0 and the high byte at address 1.
- R3: A write to address 1 stages the new high byte and a write to address 0 stages the new low word and arms a load. The counter keeps counting its old value until the next `slow_tick`, which loads the staged value in place of an increment.
- R4: Alarm flag bit 0 is set when the counter advances by increment onto the alarm value (low word at address 2, high byte at address 3). A tick that loads a staged value equal to the alarm does not set it.
- R5: Warning flag bit 2 is set when the counter advances into the state where its top 8 bits are all ones and the rest are zero (0xFF_0000_0000).
- R6: The counter wraps from all ones to zero on a tick.
- R7: Writing a nonzero N to the reload register (address 4) loads the periodic count (readable at address 5). On every N-th `fast_tick` after that, periodic flag bit 1 is set and the count restarts from N.
- R8: With reload 0 the periodic timer is off: its count stays 0 and flag bit 1 never sets.
- R9: A read of address 0 captures the counter's high byte. Address 1 then returns that captured byte, even if the counter has since carried into it.
- R10: Flags are sticky and are cleared by writing 1 to their bit at address 6. An event in the same cycle as a clear of its bit leaves the flag set.
- R11: `irq` is high exactly when some flag is set together with its enable bit at address 7 (same bit positions).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable at 32.768 kHz rate |
| fast_tick | input | 1 | One-cycle enable for the periodic timer |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the coherent capture) |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A flag being set by its event and being cleared by a software write can fall in the same clock cycle. The bench provokes this by programming the periodic timer with a period of one tick. It first lets the flag set, then raises `fast_tick` in the same cycle as a write of 1 to that flag bit, and expects the flag to read back set. A second collision is a slow tick arriving while a time load is pending, where the alarm compare must stay quiet even though the loaded value equals the alarm.

// File: rtl/rtc_pkg.sv
// Package: register addresses and flag bit positions shared by the RTC.
// Assumes a 4-bit word address space; unlisted addresses read as zero.
package rtc_pkg;
    localparam logic [3:0] A_TIME_LO  = 4'd0;
    localparam logic [3:0] A_TIME_HI  = 4'd1;
    localparam logic [3:0] A_ALARM_LO = 4'd2;
    localparam logic [3:0] A_ALARM_HI = 4'd3;
    localparam logic [3:0] A_RELOAD   = 4'd4;
    localparam logic [3:0] A_PERIOD   = 4'd5;
    localparam logic [3:0] A_FLAGS    = 4'd6;
    localparam logic [3:0] A_ENABLE   = 4'd7;

    localparam int NFLAGS  = 3;
    localparam int F_ALARM = 0;
    localparam int F_PER   = 1;
    localparam int F_WARN  = 2;
endpackage

// File: rtl/rtc_time_counter.sv
// Time counter: increments on each tick, or loads a staged value on the
// tick after a load was armed. Reports alarm matches and the pre-wrap
// warning only for increments. Assumes WARN_BITS < CNT_W.
module rtc_time_counter #(
    parameter int CNT_W     = 40,
    parameter int WARN_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_pend,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] cnt,
    output logic             alarm_hit,
    output logic             warn_hit
);
    localparam int LOW_W = CNT_W - WARN_BITS;

    logic [CNT_W-1:0] cnt_q;
    logic             adv_q;

    // Counter update: load staged value or advance by one on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            adv_q <= 1'b0;
        end else begin
            adv_q <= tick && !load_pend;
            if (tick) begin
                if (load_pend) cnt_q <= load_val;
                else           cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Event decode, valid only in the cycle after an incrementing tick.
    always_comb begin
        alarm_hit = adv_q && (cnt_q == alarm);
        warn_hit  = adv_q && (&cnt_q[CNT_W-1 -: WARN_BITS])
                          && (cnt_q[LOW_W-1:0] == '0);
    end

    assign cnt = cnt_q;

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_pend && (&cnt_q)) |=> (cnt_q == '0));
    // R4
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load_pend) |=> !alarm_hit);
endmodule

// File: rtl/rtc_periodic.sv
// Periodic down-counter: counts fast ticks, signals expiry when it passes
// through one, and restarts from the reload value. A reload of zero parks
// it at zero. Assumes a write of the reload also restarts the count.
module rtc_periodic #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_reload,
    input  logic [PER_W-1:0] reload_val,
    output logic [PER_W-1:0] cnt,
    output logic             expire
);
    logic [PER_W-1:0] reload_q;
    logic [PER_W-1:0] cnt_q;

    // Reload register and count sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (wr_reload) begin
            reload_q <= reload_val;
            cnt_q    <= reload_val;
        end else if (tick) begin
            if (reload_q == '0)                     cnt_q <= '0;
            else if (cnt_q <= PER_W'(1))            cnt_q <= reload_q;
            else                                    cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry pulse in the cycle the count runs out.
    assign expire = tick && !wr_reload && (reload_q != '0) && (cnt_q == PER_W'(1));
    assign cnt    = cnt_q;

    // R8
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q == '0 && !wr_reload) |=> (cnt_q == '0));
    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/rtc_irq_flags.sv
// Sticky event flags with write-one-to-clear and an enable mask feeding
// a single interrupt line. A set in the clearing cycle wins.
module rtc_irq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flags_q;

    // Flag state: clear requested bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & en_i);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/rtc_alarm_timer.sv
// RTC top: register port, time staging, alarm register, coherent-read
// capture, and wiring of counter, periodic timer and flags.
// Assumes CNT_W is between 33 and 64 and PER_W is at most 32.
module rtc_alarm_timer #(
    parameter int CNT_W     = 40,
    parameter int WARN_BITS = 8,
    parameter int PER_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_tick,
    input  logic        fast_tick,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    import rtc_pkg::*;

    localparam int HI_W = CNT_W - 32;

    logic [CNT_W-1:0]  stage_q;
    logic              pend_q;
    logic [CNT_W-1:0]  alarm_q;
    logic [HI_W-1:0]   snap_q;
    logic [NFLAGS-1:0] en_q;
    logic [CNT_W-1:0]  cnt;
    logic [PER_W-1:0]  per_cnt;
    logic              alarm_hit, warn_hit, expire;
    logic [NFLAGS-1:0] flags, set_v, clr_v;
    logic              wr_reload;

    // Register writes: time staging, alarm value, enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            pend_q  <= 1'b0;
            alarm_q <= '1;
            en_q    <= '0;
        end else begin
            if (slow_tick) pend_q <= 1'b0;
            if (wr_en) begin
                case (addr)
                    A_TIME_LO:  begin stage_q[31:0] <= wdata; pend_q <= 1'b1; end
                    A_TIME_HI:  stage_q[CNT_W-1:32] <= wdata[HI_W-1:0];
                    A_ALARM_LO: alarm_q[31:0] <= wdata;
                    A_ALARM_HI: alarm_q[CNT_W-1:32] <= wdata[HI_W-1:0];
                    A_ENABLE:   en_q <= wdata[NFLAGS-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Coherent read: capture the high part when the low word is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          snap_q <= '0;
        else if (rd_en && addr == A_TIME_LO) snap_q <= cnt[CNT_W-1:32];
    end

    assign wr_reload = wr_en && (addr == A_RELOAD);

    // Event and clear vectors in flag bit order.
    always_comb begin
        set_v          = '0;
        set_v[F_ALARM] = alarm_hit;
        set_v[F_PER]   = expire;
        set_v[F_WARN]  = warn_hit;
        clr_v          = (wr_en && addr == A_FLAGS) ? wdata[NFLAGS-1:0] : '0;
    end

    rtc_time_counter #(.CNT_W(CNT_W), .WARN_BITS(WARN_BITS)) u_time (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick), .load_pend(pend_q),
        .load_val(stage_q), .alarm(alarm_q), .cnt(cnt),
        .alarm_hit(alarm_hit), .warn_hit(warn_hit)
    );

    rtc_periodic #(.PER_W(PER_W)) u_per (
        .clk(clk), .rst_n(rst_n), .tick(fast_tick), .wr_reload(wr_reload),
        .reload_val(wdata[PER_W-1:0]), .cnt(per_cnt), .expire(expire)
    );

    rtc_irq_flags #(.N(NFLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
        .en_i(en_q), .flags(flags), .irq(irq)
    );

    // Read mux, zero-extending narrow fields.
    always_comb begin
        case (addr)
            A_TIME_LO:  rdata = cnt[31:0];
            A_TIME_HI:  rdata = 32'(snap_q);
            A_ALARM_LO: rdata = alarm_q[31:0];
            A_ALARM_HI: rdata = 32'(alarm_q[CNT_W-1:32]);
            A_RELOAD:   rdata = 32'(u_per.reload_q);
            A_PERIOD:   rdata = 32'(per_cnt);
            A_FLAGS:    rdata = 32'(flags);
            A_ENABLE:   rdata = 32'(en_q);
            default:    rdata = '0;
        endcase
    end

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & en_q) == '0) |-> !irq);
    // R3
    load_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TIME_LO && !slow_tick) |=> pend_q);
endmodule

// File: tb/rtc_alarm_timer_bench.sv
module rtc_alarm_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0, fast_tick = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    typedef struct {
        logic [31:0] got;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  pushed;
    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_timer u_rtc_alarm_timer (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    // Monitor: pops expected/actual pairs and compares them.
    initial begin
        forever begin
            @(pushed);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                compared++;
                if (it.got !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s got=%h expected=%h", it.tag, it.got, it.exp);
                end
            end
        end
    end

    task automatic push(input logic [31:0] got, input logic [31:0] exp, input string tag);
        item_t it;
        it.got = got; it.exp = exp; it.tag = tag;
        q.push_back(it);
        ->pushed;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 push(rdata, exp, tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        push({31'b0, irq}, {31'b0, exp}, tag);
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic fast(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still summarizes.
    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog (all requirements) got=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Driver: stimulus sequence with expected values.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, 32'h0, "R1 time lo");
        rd(4'd1, 32'h0, "R1 time hi");
        rd(4'd2, 32'hFFFF_FFFF, "R1 alarm lo");
        rd(4'd6, 32'h0, "R1 flags");
        rd(4'd7, 32'h0, "R1 enable");
        chk_irq(1'b0, "R1 irq");
        // R2 advance only on slow ticks
        slow(3);
        rd(4'd0, 32'd3, "R2 after 3 ticks");
        fast(4);
        rd(4'd0, 32'd3, "R2 hold without slow tick");
        // R3 staged load on next tick
        wr(4'd1, 32'h12);
        wr(4'd0, 32'h34);
        rd(4'd0, 32'd3, "R3 before tick");
        slow(1);
        rd(4'd0, 32'h34, "R3 loaded lo");
        rd(4'd1, 32'h12, "R3 loaded hi");
        // R4 alarm on increment
        wr(4'd3, 32'h12);
        wr(4'd2, 32'h36);
        slow(1);
        rd(4'd6, 32'h0, "R4 one short");
        slow(1);
        rd(4'd6, 32'h1, "R4 alarm flag");
        slow(1);
        rd(4'd6, 32'h1, "R10 sticky");
        wr(4'd6, 32'h1);
        rd(4'd6, 32'h0, "R10 cleared");
        // R4 load equal to alarm stays quiet
        wr(4'd1, 32'h12);
        wr(4'd0, 32'h36);
        slow(1);
        rd(4'd0, 32'h36, "R4 load value");
        rd(4'd6, 32'h0, "R4 load suppressed");
        // R11 enable gating
        wr(4'd7, 32'h1);
        chk_irq(1'b0, "R11 no flag");
        wr(4'd0, 32'h40);
        slow(1);
        wr(4'd2, 32'h41);
        slow(1);
        chk_irq(1'b1, "R11 enabled alarm");
        wr(4'd7, 32'h0);
        chk_irq(1'b0, "R11 disabled");
        wr(4'd6, 32'h7);
        // R5 pre-wrap warning
        wr(4'd1, 32'hFE);
        wr(4'd0, 32'hFFFF_FFFF);
        slow(1);
        rd(4'd6, 32'h0, "R5 before");
        slow(1);
        rd(4'd6, 32'h4, "R5 warning");
        wr(4'd6, 32'h4);
        // R6 wrap to zero
        wr(4'd1, 32'hFF);
        wr(4'd0, 32'hFFFF_FFFE);
        slow(3);
        rd(4'd0, 32'h0, "R6 wrapped lo");
        rd(4'd1, 32'h0, "R6 wrapped hi");
        // R9 coherent read across carry
        wr(4'd1, 32'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        slow(1);
        rd(4'd0, 32'hFFFF_FFFF, "R9 lo");
        slow(1);
        rd(4'd1, 32'h0, "R9 captured hi");
        rd(4'd0, 32'h0, "R9 new lo");
        rd(4'd1, 32'h1, "R9 new hi");
        // R7 periodic timer
        wr(4'd4, 32'd3);
        rd(4'd5, 32'd3, "R7 loaded");
        fast(2);
        rd(4'd5, 32'd1, "R7 count");
        rd(4'd6, 32'h0, "R7 not yet");
        fast(1);
        rd(4'd6, 32'h2, "R7 expired");
        rd(4'd5, 32'd3, "R7 restarted");
        wr(4'd6, 32'h2);
        fast(3);
        rd(4'd6, 32'h2, "R7 second period");
        wr(4'd6, 32'h2);
        // R8 reload zero disables
        wr(4'd4, 32'd0);
        fast(5);
        rd(4'd5, 32'd0, "R8 count");
        rd(4'd6, 32'h0, "R8 no flag");
        // R10 event beats clear in the same cycle
        wr(4'd4, 32'd1);
        fast(1);
        @(negedge clk);
        fast_tick = 1'b1; wr_en = 1'b1; addr = 4'd6; wdata = 32'h2;
        @(negedge clk);
        fast_tick = 1'b0; wr_en = 1'b0;
        rd(4'd6, 32'h2, "R10 set wins");
        wr(4'd4, 32'd0);
        wr(4'd6, 32'h7);
        rd(4'd6, 32'h0, "R10 final clear");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule